// File: doc/BRIEF.md
# Shared-Divider Event Timer with Watchdog

This block holds an 8-bit event counter and a watchdog counter, with one 8-bit programmable divider between them. A configuration byte sets three things: whether the counter follows instruction-cycle enables or edges on an external pin, which pin edge counts, and which side owns the divider. When the counter owns the divider, every counter step takes a power-of-two number of source events, from 2 up to 256. When the watchdog owns it, the watchdog's tick input is divided by 1 up to 128, and the counter then steps once per source event.

The external pin passes through a two-stage synchroniser and an edge detector before it reaches the counting logic. The counter has a write port, and a write clears the partial divider count when the counter owns the divider. It also has an overflow flag that holds once set, with a separate clear. The watchdog expires after 2^DOG_W divided ticks and reports this with a one-cycle pulse. Its clear input restarts it, and also restarts the divider when the watchdog owns the divider.

Top module: `tmr_dog_prescale`

## Requirements
- R1: With configuration bit 5 = 0 (internal source), the counter advances only on cycles where `cyc_en` is high; on any other cycle with no write it holds its value.
- R2: With bit 5 = 1 (external source), the counter counts edges of `ext_pin` and ignores `cyc_en`. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges. With a 1:1 ratio, the count changes on the third rising clock edge after the pin changes.
- R3: With bit 3 = 0, the divider sits in front of the counter. The counter steps once per 2^(rate+1) source events, where rate = bits [2:0] (000 gives 1:2, 111 gives 1:256).
- R4: With bit 3 = 1, the counter steps on every source event (1:1), and the watchdog advances once per 2^rate ticks of `dog_tick` (000 gives 1:1, 111 gives 1:128).
- R5: `tmr_ovf` sets when a counter step wraps FFh to 00h. It stays set until `flag_clr`, and a new wrap in the same cycle as `flag_clr` leaves it set.
- R6: After reset, `opt_q` = FFh, `tmr_q` = 00h, `tmr_ovf` = 0 and `dog_timeout` = 0, and the watchdog and divider counts are zero.
- R7: `dog_timeout` is high for exactly one cycle, after the clock edge that takes in the 2^DOG_W-th divided watchdog tick since the last clear. With bit 3 = 0 the watchdog is undivided.
- R8: `tmr_wr` loads `tmr_wdata` into the counter and takes priority over a count in the same cycle. It clears the divider only when bit 3 = 0.
- R9: `dog_clear` zeroes the watchdog count and blocks a pulse in the same cycle. It clears the divider only when bit 3 = 1.
- R10: `opt_wr` loads `opt_wdata` into the configuration byte, which is visible on `opt_q` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, the internal count source |
| ext_pin | input | 1 | Asynchronous external count pin |
| dog_tick | input | 1 | Watchdog tick enable |
| dog_clear | input | 1 | Watchdog restart |
| opt_wr | input | 1 | Configuration byte write strobe |
| opt_wdata | input | 8 | Configuration byte write data |
| tmr_wr | input | 1 | Counter write strobe |
| tmr_wdata | input | 8 | Counter write data |
| flag_clr | input | 1 | Clears the overflow flag |
| opt_q | output | 8 | Current configuration byte |
| tmr_q | output | 8 | Counter value |
| tmr_ovf | output | 1 | Sticky overflow flag |
| dog_timeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Configuration writes, counter writes, internal-source counts and the overflow flag all take effect at the first clock edge that samples the stimulus. The watchdog pulse appears after the edge that takes in its final tick. An external pin change reaches the counter only on the third edge. The bench drives inputs one time unit after a rising edge and samples one time unit after the next edge. For the pin, it checks the count after the second edge (still unchanged) and after the third (incremented). Divider ratios are swept across all eight rate codes on both sides, and each expected value is computed as an integer quotient of the number of events applied.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    localparam int OPT_W        = 8;
    localparam int OPT_SRC_BIT  = 5;
    localparam int OPT_EDGE_BIT = 4;
    localparam int OPT_ASG_BIT  = 3;
    localparam int RATE_W       = 3;

    typedef struct packed {
        logic              src_ext;
        logic              fall_edge;
        logic              to_dog;
        logic [RATE_W-1:0] rate;
    } opt_fields_t;

    function automatic opt_fields_t decode_opt(input logic [OPT_W-1:0] b);
        opt_fields_t f;
        f.src_ext   = b[OPT_SRC_BIT];
        f.fall_edge = b[OPT_EDGE_BIT];
        f.to_dog    = b[OPT_ASG_BIT];
        f.rate      = b[RATE_W-1:0];
        return f;
    endfunction
endpackage

// File: rtl/tdp_pin_sync.sv
module tdp_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic rise, fall;
    assign rise = st_q.s2 & ~st_q.prev;
    assign fall = ~st_q.s2 & st_q.prev;
    assign evt  = fall_sel ? fall : rise;
endmodule

// File: rtl/tdp_divider.sv
module tdp_divider #(
    parameter int DIV_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              to_dog,
    input  logic [RATE_W-1:0] rate,
    input  logic              tmr_evt,
    input  logic              dog_tick,
    input  logic              tmr_wr,
    input  logic              dog_clear,
    output logic              tmr_step,
    output logic              dog_step
);
    localparam int K_W = RATE_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t st_q, st_d;

    logic             src;
    logic [K_W-1:0]   k;
    logic [DIV_W:0]   lowmask;
    logic [DIV_W-1:0] nxt;
    logic             full;
    logic             div_out;
    logic             clr;

    always_comb begin
        src     = to_dog ? dog_tick : tmr_evt;
        k       = to_dog ? {1'b0, rate} : ({1'b0, rate} + K_W'(1));
        lowmask = ~({(DIV_W+1){1'b1}} << k);
        nxt     = st_q.cnt + DIV_W'(1);
        full    = ((nxt & lowmask[DIV_W-1:0]) == '0);
        div_out = src & full;
        clr     = to_dog ? dog_clear : tmr_wr;

        st_d = st_q;
        if (clr)      st_d.cnt = '0;
        else if (src) st_d.cnt = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_step = to_dog ? tmr_evt : div_out;
    assign dog_step = to_dog ? div_out : dog_tick;
endmodule

// File: rtl/tdp_timer.sv
module tdp_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr,
    input  logic [TMR_W-1:0] wdata,
    input  logic             flag_clr,
    output logic [TMR_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [TMR_W-1:0] TOP = '1;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             ovf;
    } tmr_t;

    tmr_t st_q, st_d;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (wr) begin
            st_d.cnt = wdata;
        end else if (step) begin
            st_d.cnt = st_q.cnt + TMR_W'(1);
            wrap     = (st_q.cnt == TOP);
        end
        if (wrap)          st_d.ovf = 1'b1;
        else if (flag_clr) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/tdp_watchdog.sv
module tdp_watchdog #(
    parameter int DOG_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic timeout
);
    localparam logic [DOG_W-1:0] TOP = '1;

    typedef struct packed {
        logic [DOG_W-1:0] cnt;
        logic             to;
    } dog_t;

    dog_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.to = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + DOG_W'(1);
            st_d.to  = (st_q.cnt == TOP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timeout = st_q.to;
endmodule

// File: rtl/tmr_dog_prescale.sv
module tmr_dog_prescale
    import tdp_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int DIV_W = 8,
    parameter int DOG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             dog_tick,
    input  logic             dog_clear,
    input  logic             opt_wr,
    input  logic [OPT_W-1:0] opt_wdata,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             flag_clr,
    output logic [OPT_W-1:0] opt_q,
    output logic [TMR_W-1:0] tmr_q,
    output logic             tmr_ovf,
    output logic             dog_timeout
);
    typedef struct packed {
        logic [OPT_W-1:0] opt;
    } top_t;

    top_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (opt_wr) st_d.opt = opt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.opt <= '1;
        else        st_q     <= st_d;
    end

    opt_fields_t f;
    assign f     = decode_opt(st_q.opt);
    assign opt_q = st_q.opt;

    logic pin_evt, tmr_evt, tmr_step, dog_step;

    tdp_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .fall_sel (f.fall_edge),
        .evt      (pin_evt)
    );

    assign tmr_evt = f.src_ext ? pin_evt : cyc_en;

    tdp_divider #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .to_dog    (f.to_dog),
        .rate      (f.rate),
        .tmr_evt   (tmr_evt),
        .dog_tick  (dog_tick),
        .tmr_wr    (tmr_wr),
        .dog_clear (dog_clear),
        .tmr_step  (tmr_step),
        .dog_step  (dog_step)
    );

    tdp_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tmr_step),
        .wr       (tmr_wr),
        .wdata    (tmr_wdata),
        .flag_clr (flag_clr),
        .cnt      (tmr_q),
        .ovf      (tmr_ovf)
    );

    tdp_watchdog #(.DOG_W(DOG_W)) u_dog (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (dog_step),
        .clear   (dog_clear),
        .timeout (dog_timeout)
    );
endmodule

// File: rtl/tmr_dog_prescale_chk.sv
module tmr_dog_prescale_chk #(
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_en,
    input logic             dog_clear,
    input logic             opt_wr,
    input logic [7:0]       opt_wdata,
    input logic             tmr_wr,
    input logic [TMR_W-1:0] tmr_wdata,
    input logic             flag_clr,
    input logic [7:0]       opt_q,
    input logic [TMR_W-1:0] tmr_q,
    input logic             tmr_ovf,
    input logic             dog_timeout
);
    // R1
    p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!opt_q[5] && !cyc_en && !tmr_wr) |=> (tmr_q == $past(tmr_q)));
    // R5
    p_ovf_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_ovf) |-> ($past(tmr_q) == '1 && tmr_q == '0));
    // R5
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && !flag_clr) |=> tmr_ovf);
    // R7
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dog_timeout |=> !dog_timeout);
    // R8
    p_write_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> (tmr_q == $past(tmr_wdata)));
    // R9
    p_clear_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dog_clear |=> !dog_timeout);
    // R10
    p_opt_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        opt_wr |=> (opt_q == $past(opt_wdata)));
    // R10
    p_opt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_wr |=> $stable(opt_q));
endmodule

bind tmr_dog_prescale tmr_dog_prescale_chk #(.TMR_W(TMR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_en      (cyc_en),
    .dog_clear   (dog_clear),
    .opt_wr      (opt_wr),
    .opt_wdata   (opt_wdata),
    .tmr_wr      (tmr_wr),
    .tmr_wdata   (tmr_wdata),
    .flag_clr    (flag_clr),
    .opt_q       (opt_q),
    .tmr_q       (tmr_q),
    .tmr_ovf     (tmr_ovf),
    .dog_timeout (dog_timeout)
);

// File: tb/tmr_dog_prescale_test.sv
`timescale 1ns/1ps
module tmr_dog_prescale_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 0, ext_pin = 0, dog_tick = 0, dog_clear = 0;
    logic       opt_wr = 0, tmr_wr = 0, flag_clr = 0;
    logic [7:0] opt_wdata = 0, tmr_wdata = 0;
    logic [7:0] opt_q, tmr_q;
    logic       tmr_ovf, dog_timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_dog_prescale uut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .dog_tick(dog_tick), .dog_clear(dog_clear), .opt_wr(opt_wr),
        .opt_wdata(opt_wdata), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
        .flag_clr(flag_clr), .opt_q(opt_q), .tmr_q(tmr_q),
        .tmr_ovf(tmr_ovf), .dog_timeout(dog_timeout)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_opt(input logic [7:0] v);
        opt_wr = 1; opt_wdata = v; tick(); opt_wr = 0;
    endtask

    task automatic wr_tmr(input logic [7:0] v);
        tmr_wr = 1; tmr_wdata = v; tick(); tmr_wr = 0;
    endtask

    task automatic count_int(input int n);
        cyc_en = 1;
        for (int i = 0; i < n; i++) tick();
        cyc_en = 0;
    endtask

    task automatic pin_pulse();
        ext_pin = 1; repeat (3) tick();
        ext_pin = 0; repeat (3) tick();
    endtask

    task automatic clear_dog();
        dog_clear = 1; tick(); dog_clear = 0;
    endtask

    // Feed n watchdog ticks; report early pulses and whether the last one pulsed.
    task automatic dog_run(input int n, output int early, output int last);
        early = 0; last = 0;
        dog_tick = 1;
        for (int i = 1; i <= n; i++) begin
            tick();
            if (i < n && dog_timeout) early++;
            if (i == n) last = dog_timeout;
        end
        dog_tick = 0;
    endtask

    initial begin
        int early, last, ratio;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R6 reset state
        chk("R6 opt reset", opt_q, 8'hFF);
        chk("R6 tmr reset", tmr_q, 0);
        chk("R6 ovf reset", tmr_ovf, 0);
        chk("R6 timeout reset", dog_timeout, 0);

        // R3 / R8: divider in front of the counter, every rate
        for (int r = 0; r < 8; r++) begin
            ratio = 2 << r;
            set_opt(8'hC0 | r);
            chk("R10 opt load", opt_q, 8'hC0 | r);
            count_int(ratio / 2);
            wr_tmr(8'h00);              // R8 also clears divider
            count_int(ratio - 1);
            chk("R3/R8 one short of ratio", tmr_q, 0);
            count_int(1);
            chk("R3 one step", tmr_q, 1);
            count_int(3 * ratio);
            chk("R3 four steps", tmr_q, 4);
        end

        // R4 / R5: undivided counting, overflow
        set_opt(8'hC8);
        wr_tmr(8'hF0);
        count_int(20);
        chk("R4 undivided wrap value", tmr_q, 8'h04);
        chk("R5 ovf set on wrap", tmr_ovf, 1);
        count_int(3);
        chk("R5 ovf sticky", tmr_ovf, 1);
        flag_clr = 1; tick(); flag_clr = 0;
        chk("R5 ovf cleared", tmr_ovf, 0);
        wr_tmr(8'hFF);
        cyc_en = 1; flag_clr = 1; tick(); cyc_en = 0; flag_clr = 0;
        chk("R5 wrap wins over clear", tmr_ovf, 1);
        chk("R5 wrap value", tmr_q, 0);
        flag_clr = 1; tick(); flag_clr = 0;

        // R1: no cycle enable, no count
        wr_tmr(8'h33);
        repeat (10) tick();
        chk("R1 idle hold", tmr_q, 8'h33);
        // R8: write beats count
        tmr_wr = 1; tmr_wdata = 8'h55; cyc_en = 1; tick(); tmr_wr = 0; cyc_en = 0;
        chk("R8 write priority", tmr_q, 8'h55);

        // R2: external rising edges, cyc_en ignored
        set_opt(8'hE8);
        wr_tmr(8'h00);
        cyc_en = 1;
        ext_pin = 1;
        tick(); tick();
        chk("R2 no change after 2 edges", tmr_q, 0);
        tick();
        chk("R2 count on 3rd edge", tmr_q, 1);
        repeat (2) tick();
        ext_pin = 0; repeat (3) tick();
        for (int i = 0; i < 4; i++) pin_pulse();
        chk("R2 rising count", tmr_q, 5);
        // falling edges
        set_opt(8'hF8);
        wr_tmr(8'h00);
        ext_pin = 1; repeat (4) tick();
        chk("R2 rising ignored in falling mode", tmr_q, 0);
        ext_pin = 0; tick(); tick();
        chk("R2 falling not yet", tmr_q, 0);
        tick();
        chk("R2 falling on 3rd edge", tmr_q, 1);
        for (int i = 0; i < 3; i++) pin_pulse();
        chk("R2 falling count", tmr_q, 4);
        // external through 1:2 divider
        set_opt(8'hE0);
        wr_tmr(8'h00);
        for (int i = 0; i < 4; i++) pin_pulse();
        chk("R3 external divided", tmr_q, 2);
        cyc_en = 0;

        // R9: dog_clear leaves divider alone when counter owns it
        set_opt(8'hC0);
        wr_tmr(8'h00);
        count_int(1);
        clear_dog();
        count_int(1);
        chk("R9 clear keeps timer divider", tmr_q, 1);

        // R8: counter write leaves divider alone when watchdog owns it
        set_opt(8'hC9);
        clear_dog();
        dog_run(511, early, last);
        wr_tmr(8'h00);
        dog_run(1, early, last);
        chk("R8 write keeps dog divider", last, 1);

        // R7: undivided watchdog
        set_opt(8'hC0);
        clear_dog();
        dog_run(256, early, last);
        chk("R7 no early pulse", early, 0);
        chk("R7 pulse at 256", last, 1);
        tick();
        chk("R7 pulse one cycle", dog_timeout, 0);

        // R4: watchdog ratios, every rate
        for (int r = 0; r < 8; r++) begin
            set_opt(8'hC8 | r);
            clear_dog();
            dog_run(256 << r, early, last);
            chk("R4 dog no early pulse", early, 0);
            chk("R4 dog pulse at ratio", last, 1);
        end

        // R9: clear restarts the count
        set_opt(8'hC0);
        clear_dog();
        dog_run(200, early, last);
        dog_clear = 1; dog_tick = 1; tick(); dog_clear = 0; dog_tick = 0;
        chk("R9 no pulse on clear", dog_timeout, 0);
        dog_run(256, early, last);
        chk("R9 restart no early", early, 0);
        chk("R9 restart pulse", last, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule